// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block is the transmit half of a synchronous serial port that runs as a clock slave. An external master drives the shift clock on a pin. The block synchronises that clock into its own domain and finds its falling edges. On each detected falling edge it puts the next bit of the current word on the data line, least significant bit first.

Software writes words into a one-entry holding register. When the shifter is idle, a written word moves into the shifter on the next cycle. When the shifter is busy, the word waits in the holding register. A buffer-empty flag tells software when it can write the next word, and it can raise an interrupt. The flag stays clear while a word waits, and it sets in the cycle the waiting word enters the shifter.

An optional ninth bit follows the eight data bits. Shifting is paced only by the external clock, so a word can go out while the rest of the core is idle.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `buf_empty` is 1, `data_out` is at the idle level 0, and `irq` is 0 while `irq_en` is 0.
- R2: A word can only be accepted when all of these hold: `port_en`, `sync_mode` and `tx_en` are 1, and `clk_internal`, `rx_cont_en` and `rx_single_en` are 0. Otherwise a write is discarded, `buf_empty` stays 1 and `data_out` stays 0.
- R3: A write accepted while the shifter is idle clears `buf_empty` for exactly one cycle. In the next cycle the word enters the shifter, its bit 0 appears on `data_out`, and `buf_empty` returns to 1.
- R4: Bits leave least significant bit first. Each falling edge of `ext_sck` goes through a two-flop synchroniser and advances the line by one bit within three clock cycles. Without such an edge, `data_out` does not change.
- R5: A word written while another word is shifting waits in the holding register. `buf_empty` stays 0 while it waits.
- R6: The falling edge after the last bit of a word returns `data_out` to 0. If a word is waiting, it then enters the shifter, its bit 0 is driven, and `buf_empty` sets.
- R7: When `nine_en` is 1 at write time, the word is nine bits long. Bit 8 is the value `ninth_bit` had when the holding register was written, and it is shifted after bit 7.
- R8: `irq` is 1 exactly when `buf_empty` and `irq_en` are both 1.
- R9: When an enable condition of R2 drops in the middle of a word, the shifter is reset, `data_out` goes to 0, any waiting word is discarded and `buf_empty` sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_internal | input | 1 | 1 selects an internally generated clock; 0 selects slave operation |
| tx_en | input | 1 | Transmit enable |
| rx_cont_en | input | 1 | Continuous receive enable (must be 0) |
| rx_single_en | input | 1 | Single receive enable (must be 0) |
| nine_en | input | 1 | Nine-bit frames |
| ninth_bit | input | 1 | Value of the ninth bit |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Word written to the holding register |
| ext_sck | input | 1 | External shift clock from the master |
| data_out | output | 1 | Serial data line |
| buf_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt / wake request |

## Verification
A wrong bit count shows up at the end of a frame. The line goes idle one edge too early or too late, and a waiting word enters the shifter at the wrong edge. Both are visible on `data_out` and `buf_empty` within three cycles of that edge. A holding register that keeps its state after a disable shows up on the first enabled cycle, as a spurious bit on the line or a clear flag. A stale or early-sampled ninth bit only shows on the ninth frame bit, so that bit is checked after `ninth_bit` has been changed.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
  // Number of bits in one frame for a given data width and ninth-bit mode
  function automatic int unsigned frame_bits(input int unsigned data_w, input logic ninth);
    return ninth ? data_w + 1 : data_w;
  endfunction
endpackage

// File: rtl/sstx_edge_det.sv
module sstx_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  // sh[STAGES-1] is the synchronised pin value; sh[STAGES] is its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];

  // R4: two fall pulses are always separated by a rise
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter #(
  parameter int   DATA_W = 8,
  parameter logic IDLE   = 1'b0,
  localparam int  FW     = DATA_W + 1,
  localparam int  CNT_W  = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [FW-1:0]    load_word,
  input  logic [CNT_W-1:0] load_len,
  input  logic             step,
  output logic             line,
  output logic             busy
);
  logic [FW-1:0]    sreg;
  logic [CNT_W-1:0] left;
  logic             done;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sreg <= '0;
      left <= '0;
      line <= IDLE;
    end else if (load) begin
      sreg <= load_word >> 1;
      line <= load_word[0];
      left <= load_len;
    end else if (step && busy) begin
      line <= (left == CNT_W'(1)) ? IDLE : sreg[0];
      sreg <= sreg >> 1;
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
  assign done = step && (left == CNT_W'(1));

  // R4: without a detected edge the line does not change
  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step && !load && !clear |=> $stable(line));
  // R6: the last edge of a frame returns the line to idle
  a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done && !clear |=> line == IDLE && !busy);
  // R7: never more bits pending than a nine-bit frame holds
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(left) <= FW);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
  parameter int   DATA_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b0,
  localparam int  FW          = DATA_W + 1,
  localparam int  CNT_W       = $clog2(FW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_internal,
  input  logic              tx_en,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              nine_en,
  input  logic              ninth_bit,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext_sck,
  output logic              data_out,
  output logic              buf_empty,
  output logic              irq
);
  import sstx_pkg::*;

  logic             ctrl_ok, wr_take, load, sck_fall, sh_busy;
  logic             hold_full, hold_nine, empty_q;
  logic [DATA_W-1:0] hold_data;
  logic [CNT_W-1:0]  hold_len;

  assign ctrl_ok = port_en & sync_mode & ~clk_internal & tx_en & ~rx_cont_en & ~rx_single_en;
  assign wr_take = wr_en & ctrl_ok;
  assign load    = hold_full & ~sh_busy & ctrl_ok;

  sstx_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_sck), .fall(sck_fall)
  );

  // Holding register
  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl_ok) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      hold_nine <= 1'b0;
      hold_len  <= '0;
    end else if (wr_take) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
      hold_nine <= nine_en & ninth_bit;
      hold_len  <= CNT_W'(frame_bits(DATA_W, nine_en));
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  // Buffer-empty flag
  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl_ok) empty_q <= 1'b1;
    else if (wr_take)       empty_q <= 1'b0;
    else if (load)          empty_q <= 1'b1;
  end

  sstx_shifter #(.DATA_W(DATA_W), .IDLE(IDLE_LEVEL)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(!ctrl_ok), .load(load),
    .load_word({hold_nine, hold_data}), .load_len(hold_len),
    .step(sck_fall), .line(data_out), .busy(sh_busy)
  );

  assign buf_empty = empty_q;
  assign irq       = empty_q & irq_en;

  // R2: a disabled port idles with an empty buffer
  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_ok |=> buf_empty && data_out == IDLE_LEVEL);
  // R3: an accepted write clears the flag
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> !buf_empty);
  // R5: a waiting word keeps the flag clear
  a_r5_waiting_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full |-> !buf_empty);
  // R6: moving the waiting word into the shifter sets the flag
  a_r6_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
    load && !wr_take |=> buf_empty && sh_busy);
  // R8: the request needs the flag
  a_r8_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> buf_empty);
endmodule

// File: tb/tb_sync_slave_tx.sv
`timescale 1ns/1ps
module tb_sync_slave_tx;
  logic clk = 0, rst_n = 0;
  logic port_en = 0, sync_mode = 0, clk_internal = 0, tx_en = 0;
  logic rx_cont_en = 0, rx_single_en = 0, nine_en = 0, ninth_bit = 0, irq_en = 0;
  logic wr_en = 0, ext_sck = 1;
  logic [7:0] wr_data = 0;
  logic data_out, buf_empty, irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sync_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sync_mode(sync_mode),
    .clk_internal(clk_internal), .tx_en(tx_en), .rx_cont_en(rx_cont_en),
    .rx_single_en(rx_single_en), .nine_en(nine_en), .ninth_bit(ninth_bit),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .ext_sck(ext_sck),
    .data_out(data_out), .buf_empty(buf_empty), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic enable_all();
    port_en = 1; sync_mode = 1; clk_internal = 0; tx_en = 1;
    rx_cont_en = 0; rx_single_en = 0;
  endtask

  task automatic write_word(input logic [7:0] d);
    wr_data = d; wr_en = 1;
    cycles(1);
    wr_en = 0;
  endtask

  task automatic sck_fall();
    ext_sck = 0; cycles(4);
    ext_sck = 1; cycles(4);
  endtask

  task automatic t_reset();
    rst_n = 0; cycles(3); rst_n = 1; cycles(1);
    @(negedge clk);
    chk("R1 flag", buf_empty, 1);
    chk("R1 line", data_out, 0);
    chk("R1 irq", irq, 0);
    irq_en = 1; @(negedge clk);
    chk("R8 irq with empty", irq, 1);
    irq_en = 0;
  endtask

  task automatic t_basic();
    logic [7:0] d = 8'hA5;
    enable_all(); cycles(2);
    write_word(d);
    @(negedge clk); chk("R3 flag cleared one cycle", buf_empty, 0);
    @(negedge clk); chk("R3 flag set after load", buf_empty, 1);
    chk("R3 bit0 driven", data_out, d[0]);
    cycles(10);
    chk("R4 stable without edge", data_out, d[0]);
    for (int i = 0; i < 8; i++) begin
      chk("R4 lsb-first bit", data_out, d[i]);
      sck_fall();
    end
    chk("R6 idle after last", data_out, 0);
  endtask

  task automatic t_double();
    logic [7:0] a = 8'h3C, b = 8'h81;
    irq_en = 1;
    write_word(a); cycles(2);
    write_word(b); cycles(2);
    chk("R5 flag clear while waiting", buf_empty, 0);
    chk("R8 irq low while waiting", irq, 0);
    for (int i = 0; i < 7; i++) begin
      chk("R4 first word bit", data_out, a[i]);
      sck_fall();
    end
    chk("R5 still waiting before last edge", buf_empty, 0);
    chk("R4 first word bit7", data_out, a[7]);
    sck_fall();
    chk("R6 flag set on transfer", buf_empty, 1);
    chk("R8 irq on transfer", irq, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R6 second word bit", data_out, b[i]);
      sck_fall();
    end
    chk("R6 idle after second", data_out, 0);
    irq_en = 0;
  endtask

  task automatic t_nine();
    logic [7:0] d = 8'h00;
    nine_en = 1; ninth_bit = 1;
    write_word(d);
    ninth_bit = 0;
    cycles(2);
    for (int i = 0; i < 8; i++) sck_fall();
    chk("R7 ninth bit from write time", data_out, 1);
    sck_fall();
    chk("R7 idle after ninth", data_out, 0);
    nine_en = 0;
  endtask

  task automatic t_gate();
    for (int c = 0; c < 6; c++) begin
      enable_all();
      case (c)
        0: port_en = 0;
        1: sync_mode = 0;
        2: clk_internal = 1;
        3: tx_en = 0;
        4: rx_cont_en = 1;
        default: rx_single_en = 1;
      endcase
      cycles(1);
      write_word(8'hFF);
      cycles(2);
      chk("R2 flag stays set", buf_empty, 1);
      chk("R2 line idle", data_out, 0);
      enable_all(); cycles(3);
      chk("R2 write was discarded", data_out, 0);
    end
  endtask

  task automatic t_abort();
    enable_all(); cycles(1);
    write_word(8'hFF); cycles(2);
    write_word(8'hFF); cycles(1);
    sck_fall(); sck_fall();
    chk("R9 shifting before abort", data_out, 1);
    tx_en = 0; cycles(1);
    @(negedge clk);
    chk("R9 line idle", data_out, 0);
    chk("R9 flag set", buf_empty, 1);
    tx_en = 1; cycles(4);
    chk("R9 waiting word discarded", data_out, 0);
    chk("R9 flag still set", buf_empty, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_double();
    t_nine();
    t_gate();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule